// File: doc/BRIEF.md
# Host Register Port with Indirect Bank Access

This block is the control-side host port of a larger chip. An external controller reaches it over an asynchronous, SRAM-style bus made of a chip select, a read strobe, a write strobe, a four-bit address and a 32-bit data bus. The four address bits decode into sixteen direct locations. These locations hold an identification word, a bus-mode register, a control register, a small set of scratch registers, and a pointer/data pair. The pair opens onto a deeper internal register bank.

The strobes are asynchronous to the core clock, so they pass through a two-flop synchroniser. An access takes effect once, on the synchronised leading edge of its strobe. To reach a bank entry, the host writes the pointer and then reads or writes the data location. An optional auto-increment lets a run of consecutive entries load or unload without rewriting the pointer.

Bank words are 32 bits wide. When the control bus is in 16-bit mode, each bank word moves as two half-word accesses in big-endian order. All other registers are 16 bits wide. In 32-bit mode these registers ignore the upper half of the bus on writes and return zeros there on reads. The port has no valid/ready handshake, because every transfer is a single register access paced by the host's strobes. Back-pressure therefore does not apply.

Top module: `hreg_port`

## Requirements
- R1: After reset, the mode register (direct address 0x1) reads 0x0002, `ctl_wide` is 0, `data_width` is 2'b01 (16-bit), and the control register (0x2) and pointer (0x3) read 0.
- R2: Direct address 0x0 reads the constant ID_VALUE in bits 15:0, and writes to it have no effect.
- R3: A write takes effect only while chip select is low. Each strobe pulse makes exactly one access, however long the strobe is held.
- R4: In 32-bit control mode, writes to 16-bit registers ignore data bits 31:16, and reads of those registers return 0 in bits 31:16.
- R5: In the mode register, bit 0 selects the control width (0 = 16-bit, 1 = 32-bit) and drives `ctl_wide`. Bits 2:1 select the data width (0 = 8, 1 = 16, 2 = 32) and drive `data_width`. A write carrying code 3 in bits 2:1 leaves the data width unchanged.
- R6: In 32-bit control mode, a write to the data location (0x4) stores all 32 bits in the bank entry selected by the pointer, and a read returns that whole entry.
- R7: In 16-bit control mode, a bank word moves as two accesses to 0x4, upper half first. A write reaches the bank only on the second half. A write to the pointer or to the mode register restarts the half sequence.
- R8: When control bit 0 is 1, the pointer increments by one after each complete bank-word access. When that bit is 0, the pointer does not move.
- R9: With the pointer at or beyond the bank depth, reads of 0x4 return 0 and writes are dropped without changing any in-range entry.
- R10: Direct addresses 0x5–0x7 and 0xC–0xF read 0, and writes to them have no effect.
- R11: Direct addresses 0x8–0xB are 16-bit scratch registers that read back the last value written.
- R12: The read data output is loaded at the start of each read and holds that value until the next read, including across writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| addr | input | 4 | Direct register address |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Read data captured at the start of the last read |
| ctl_wide | output | 1 | Control bus width: 1 = 32-bit |
| data_width | output | 2 | Data transfer width code: 0 = 8, 1 = 16, 2 = 32 |

## Verification
Some properties are checked on every cycle by assertions. Each strobe pulse yields a single access. The read data holds steady between reads. Reads of 16-bit registers return zeros in the upper half. The pointer moves only in a cycle with an access. The data width never takes the reserved code. Other behaviour can only be shown by the bench's scenarios. This covers the big-endian half-word ordering, the commit on the second half, auto-increment across a full-bank burst, dropped writes beyond the bank, and writes that are ignored without chip select.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam logic [3:0] A_ID    = 4'h0;
  localparam logic [3:0] A_MODE  = 4'h1;
  localparam logic [3:0] A_CTRL  = 4'h2;
  localparam logic [3:0] A_PTR   = 4'h3;
  localparam logic [3:0] A_DATA  = 4'h4;
  localparam logic [3:0] A_SCR0  = 4'h8;

  localparam logic [1:0] DW_RSVD = 2'b11;
  localparam logic [1:0] DW_16   = 2'b01;

  localparam int HALF = 16;
  localparam int BUS  = 32;
endpackage

// File: rtl/hreg_sync.sv
module hreg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hreg_strobe.sv
module hreg_strobe #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] act,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl, lvl_d;

  hreg_sync #(.W(N)) u_sync (.clk(clk), .rst_n(rst_n), .d(act), .q(lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= '0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/hreg_bank.sv
module hreg_bank #(
  parameter int DEPTH = 64,
  parameter int IA_W  = 8,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IA_W-1:0] idx,
  input  logic [DW-1:0]   wdat,
  output logic [DW-1:0]   rdat
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic          in_range;

  assign in_range = ({1'b0, idx} < (IA_W+1)'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && in_range) begin
      mem[idx[AW-1:0]] <= wdat;
    end
  end

  assign rdat = in_range ? mem[idx[AW-1:0]] : '0;
endmodule

// File: rtl/hreg_port.sv
module hreg_port #(
  parameter int          DEPTH    = 64,
  parameter int          IA_W     = 8,
  parameter int          N_SCR    = 4,
  parameter logic [15:0] ID_VALUE = 16'h2C5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        ctl_wide,
  output logic [1:0]  data_width
);
  import hreg_pkg::*;

  localparam int SW = 4 + BUS;

  // synchronised strobes and bus
  logic [1:0]    evt;
  logic          rd_evt, wr_evt;
  logic [SW-1:0] bus_q;
  logic [3:0]    a;
  logic [31:0]   wd;

  hreg_strobe #(.N(2)) u_strobe (
    .clk(clk), .rst_n(rst_n),
    .act({~cs_n & ~wr_n, ~cs_n & ~rd_n}),
    .rise(evt)
  );
  assign rd_evt = evt[0];
  assign wr_evt = evt[1];

  hreg_sync #(.W(SW)) u_bus (.clk(clk), .rst_n(rst_n), .d({addr, wdata}), .q(bus_q));
  assign a  = bus_q[SW-1 -: 4];
  assign wd = bus_q[BUS-1:0];

  // register state
  logic            ctl32, inc_en, half;
  logic [1:0]      dw;
  logic [IA_W-1:0] ptr;
  logic [15:0]     hi_buf, lo_hold;
  logic [15:0]     scr [N_SCR];
  logic [31:0]     bank_rd, bank_wd, rd_mux;
  logic            data_acc, word_done, bank_we;

  assign data_acc  = (rd_evt || wr_evt) && (a == A_DATA);
  assign word_done = data_acc && (ctl32 || half);
  assign bank_we   = wr_evt && (a == A_DATA) && (ctl32 || half);
  assign bank_wd   = ctl32 ? wd : {hi_buf, wd[15:0]};

  hreg_bank #(.DEPTH(DEPTH), .IA_W(IA_W), .DW(BUS)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .idx(ptr), .wdat(bank_wd), .rdat(bank_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl32  <= 1'b0;
      dw     <= DW_16;
      inc_en <= 1'b0;
    end else if (wr_evt) begin
      if (a == A_MODE) begin
        ctl32 <= wd[0];
        if (wd[2:1] != DW_RSVD) dw <= wd[2:1];
      end
      if (a == A_CTRL) inc_en <= wd[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_evt && (a == A_PTR)) begin
      ptr <= wd[IA_W-1:0];
    end else if (word_done && inc_en) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half    <= 1'b0;
      hi_buf  <= '0;
      lo_hold <= '0;
    end else begin
      if (wr_evt && ((a == A_PTR) || (a == A_MODE))) half <= 1'b0;
      else if (data_acc && !ctl32)                   half <= ~half;
      if (wr_evt && (a == A_DATA) && !ctl32 && !half) hi_buf  <= wd[15:0];
      if (rd_evt && (a == A_DATA) && !ctl32 && !half) lo_hold <= bank_rd[15:0];
    end
  end

  for (genvar i = 0; i < N_SCR; i++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scr[i] <= '0;
      else if (wr_evt && (a == A_SCR0 + 4'(i))) scr[i] <= wd[15:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (a == A_ID)        rd_mux = {16'h0, ID_VALUE};
    else if (a == A_MODE) rd_mux = {29'h0, dw, ctl32};
    else if (a == A_CTRL) rd_mux = {31'h0, inc_en};
    else if (a == A_PTR)  rd_mux = 32'(ptr);
    else if (a == A_DATA) begin
      if (ctl32)     rd_mux = bank_rd;
      else if (half) rd_mux = {16'h0, lo_hold};
      else           rd_mux = {16'h0, bank_rd[31:16]};
    end else begin
      for (int i = 0; i < N_SCR; i++)
        if (a == A_SCR0 + 4'(i)) rd_mux = {16'h0, scr[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_evt) rdata <= rd_mux;
  end

  assign ctl_wide   = ctl32;
  assign data_width = dw;

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(rdata));
  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && (a != A_DATA) && (a != A_PTR)) |=> (rdata[31:16] == 16'h0));
  // R8
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_evt || wr_evt) |=> $stable(ptr));
  // R5
  dw_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_width != DW_RSVD);
endmodule

// File: tb/hreg_port_test.sv
module hreg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam logic [15:0] IDV = 16'h2C5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ctl_wide;
  logic [1:0]  data_width;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] expw [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  hreg_port #(.DEPTH(DEPTH), .IA_W(8), .N_SCR(4), .ID_VALUE(IDV)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .ctl_wide(ctl_wide), .data_width(data_width)
  );

  function automatic logic [31:0] pat(int i);
    return (32'(i) * 32'h0101_0101) ^ 32'h5A3C_00A5;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, int hold = 5, bit sel = 1'b1);
    @(negedge clk);
    addr = a; wdata = d; cs_n = ~sel; wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d, input int hold = 5);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    repeat (hold) @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, hold_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(4'h1, v); check("R1 mode", v, 32'h2);
    check("R1 ctl_wide", 32'(ctl_wide), 32'h0);
    check("R1 data_width", 32'(data_width), 32'h1);
    rd(4'h2, v); check("R1 ctrl", v, 32'h0);
    rd(4'h3, v); check("R1 ptr", v, 32'h0);

    // R2 identification word
    rd(4'h0, v); check("R2 id", v, {16'h0, IDV});
    wr(4'h0, 32'h0000_FFFF);
    rd(4'h0, v); check("R2 id after write", v, {16'h0, IDV});

    // R10 unmapped direct locations
    for (int k = 0; k < 16; k++) begin
      if ((k >= 5 && k <= 7) || k >= 12) begin
        wr(4'(k), 32'hFFFF_FFFF);
        rd(4'(k), v); check("R10 unmapped", v, 32'h0);
      end
    end

    // R11 scratch sweep
    for (int k = 0; k < 4; k++) wr(4'(8 + k), 32'(16'h1111 * (k + 3)));
    for (int k = 0; k < 4; k++) begin
      rd(4'(8 + k), v); check("R11 scratch", v, 32'(16'h1111 * (k + 3)));
    end

    // R3 no chip select: ignored
    wr(4'h8, 32'h0000_0BAD, 5, 1'b0);
    rd(4'h8, v); check("R3 cs_n high", v, 32'h3333);

    // R5 mode fields
    wr(4'h1, 32'h0000_0005);
    check("R5 ctl_wide", 32'(ctl_wide), 32'h1);
    check("R5 data_width", 32'(data_width), 32'h2);
    wr(4'h1, 32'h0000_0007);
    check("R5 reserved width", 32'(data_width), 32'h2);
    rd(4'h1, v); check("R5 mode read", v, 32'h5);

    // R4 upper half masking in 32-bit mode
    wr(4'h9, 32'hBEEF_1234);
    rd(4'h9, v); check("R4 scratch 32b", v, 32'h0000_1234);
    rd(4'h2, v); check("R4 ctrl upper", v, 32'h0);

    // R6 R8 full-bank burst in 32-bit mode
    wr(4'h2, 32'h1);
    wr(4'h3, 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      wr(4'h4, pat(i)); expw[i] = pat(i);
    end
    rd(4'h3, v); check("R8 ptr after burst", v, 32'(DEPTH));
    wr(4'h3, 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      rd(4'h4, v); check("R6 bank word", v, expw[i]);
    end

    // R8 no increment when disabled
    wr(4'h2, 32'h0);
    wr(4'h3, 32'h5);
    wr(4'h4, 32'hAAAA_0001);
    wr(4'h4, 32'hBBBB_0002); expw[5] = 32'hBBBB_0002;
    rd(4'h3, v); check("R8 ptr static", v, 32'h5);
    rd(4'h4, v); check("R8 last write kept", v, 32'hBBBB_0002);

    // R9 beyond the bank
    wr(4'h3, 32'd70);
    wr(4'h4, 32'hDEAD_BEEF);
    rd(4'h4, v); check("R9 read beyond", v, 32'h0);
    wr(4'h3, 32'd6);
    rd(4'h4, v); check("R9 alias untouched", v, expw[6]);

    // R7 big-endian halves in 16-bit mode
    wr(4'h1, 32'h2);
    wr(4'h2, 32'h1);
    wr(4'h3, 32'd10);
    for (int i = 10; i < 14; i++) begin
      expw[i] = 32'hC0DE_0000 + 32'(i * 32'h0001_0101);
      wr(4'h4, {16'h0, expw[i][31:16]});
      wr(4'h4, {16'h0, expw[i][15:0]});
    end
    rd(4'h3, v); check("R7 ptr after pairs", v, 32'd14);
    wr(4'h3, 32'd10);
    for (int i = 10; i < 14; i++) begin
      rd(4'h4, v); check("R7 upper half first", v, {16'h0, expw[i][31:16]});
      rd(4'h4, v); check("R7 lower half second", v, {16'h0, expw[i][15:0]});
    end
    wr(4'h3, 32'd20);
    wr(4'h4, 32'h0000_7777);
    wr(4'h3, 32'd20);
    rd(4'h4, v); check("R7 single half no commit hi", v, {16'h0, expw[20][31:16]});
    rd(4'h4, v); check("R7 single half no commit lo", v, {16'h0, expw[20][15:0]});

    // R3 long strobes count once
    wr(4'h3, 32'd30);
    rd(4'h4, v, 14);
    rd(4'h4, v, 14);
    rd(4'h3, v); check("R3 long strobe one step", v, 32'd31);

    // R12 read data held across writes
    rd(4'h8, hold_v);
    wr(4'hA, 32'h0000_4321);
    check("R12 hold across write", rdata, hold_v);
    check("R12 held value", hold_v, 32'h3333);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule